// File: doc/BRIEF.md
# Parallel Quarter-Rate Complex Mixer

This block turns a wideband stream of real samples into complex baseband. It moves the spectral component that sits at one quarter of the sample rate down to DC. For example, a tone at 800 MHz in a 3200 MS/s stream lands at 0 Hz. The stream arrives several samples per clock, so a converter much faster than the logic clock can be served; the default is eight 16-bit samples per beat. No multiplier is used. Every output sample is the input sample, its negation or zero, and a commutator selects which by the sample's rotation phase.

The in-phase weights repeat 1, 0, -1, 0 over consecutive samples and the quadrature weights repeat 0, 1, 0, -1. Lane k of a beat takes rotation phase (base + k) mod 4. The base phase is kept in a small state machine with four states:

- PH_ZERO (phase 0)
- PH_QUARTER (phase 1)
- PH_HALF (phase 2)
- PH_THREE_Q (phase 3)

After reset the machine is in PH_ZERO. On every accepted beat it steps forward by LANES mod 4 states, and on idle cycles it stays where it is. With eight lanes the step is zero, so the mapping from lane to phase is the same on every beat.

Because one of I and Q is always zero for each sample, half of each output stream is known to be zero. A following filter can use this to save logic.

Top module: `qmix_quarter_rate`

## Requirements
- R1: A sample whose rotation phase is 0 gives I = x and Q = 0.
- R2: A sample whose rotation phase is 1 gives I = 0 and Q = x.
- R3: A sample whose rotation phase is 2 gives I = -x and Q = 0.
- R4: A sample whose rotation phase is 3 gives I = 0 and Q = -x.
- R5: Lane k, which occupies bits [k*DW +: DW] of every vector, uses phase (base + k) mod 4. With LANES a multiple of 4 (the default of 8), base stays 0, so lanes 0..7 take phases 0,1,2,3,0,1,2,3 on every beat.
- R6: When LANES is not a multiple of 4, base advances by LANES mod 4 after each beat with in_valid high. It holds on beats with in_valid low, and returns to 0 on reset.
- R7: Negation saturates: an input of -2^(DW-1) on a negating phase gives 2^(DW-1)-1.
- R8: Outputs appear one clock after the input beat, and out_valid equals in_valid delayed by one clock.
- R9: While in_valid is low, out_i and out_q keep their previous values.
- R10: rst_n is synchronous and active low. A clock edge with it low clears out_valid, out_i and out_q, and resets base to phase 0.
- R11: In every lane, at most one of the I and Q outputs is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat strobe |
| in_samples | input | LANES*DW | Real two's-complement samples, lane 0 oldest, in the low bits |
| out_valid | output | 1 | Output beat strobe |
| out_i | output | LANES*DW | In-phase samples, same lane layout |
| out_q | output | LANES*DW | Quadrature samples, same lane layout |

## Verification
Saturating negation and base-phase rotation can act on the same beat. This happens when the most negative value arrives on a lane whose phase has been shifted onto a negating state by earlier beats. The bench provokes this by running a second instance with six lanes, where the step per beat is 2. It feeds it runs of all-minimum and alternating extreme beats with gaps in in_valid, so the negating lanes change from beat to beat. A behavioural model keeps its own base phase and compares every lane of both instances on every clock. A wrong rotation step or a wrapping negation therefore shows up as a mismatch in a specific lane.

// File: rtl/qmix_pkg.sv
package qmix_pkg;

    // Rotation phase of one sample: index into the weight sequences
    // I: 1, 0, -1, 0   Q: 0, 1, 0, -1
    typedef enum logic [1:0] {
        PH_ZERO    = 2'd0,
        PH_QUARTER = 2'd1,
        PH_HALF    = 2'd2,
        PH_THREE_Q = 2'd3
    } rot_phase_e;

    // Phase taken by lane k given the phase of lane 0
    function automatic rot_phase_e lane_phase(rot_phase_e base, int unsigned k);
        logic [1:0] sum;
        sum = 2'(int'(base) + int'(k % 4));
        return rot_phase_e'(sum);
    endfunction

endpackage

// File: rtl/qmix_phase_fsm.sv
module qmix_phase_fsm
    import qmix_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       advance,
    output rot_phase_e base
);

    localparam int STEP = LANES % 4;

    localparam rot_phase_e NEXT_FROM_ZERO    = rot_phase_e'(2'(0 + STEP));
    localparam rot_phase_e NEXT_FROM_QUARTER = rot_phase_e'(2'(1 + STEP));
    localparam rot_phase_e NEXT_FROM_HALF    = rot_phase_e'(2'(2 + STEP));
    localparam rot_phase_e NEXT_FROM_THREE_Q = rot_phase_e'(2'(3 + STEP));

    rot_phase_e state_q;
    rot_phase_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_ZERO;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state selection: step by LANES mod 4 on each accepted beat
    always_comb begin
        state_d = state_q;
        if (advance) begin
            unique case (state_q)
                PH_ZERO:    state_d = NEXT_FROM_ZERO;
                PH_QUARTER: state_d = NEXT_FROM_QUARTER;
                PH_HALF:    state_d = NEXT_FROM_HALF;
                PH_THREE_Q: state_d = NEXT_FROM_THREE_Q;
            endcase
        end
    end

    assign base = state_q;

    // R6: phase is frozen on idle beats
    p_phase_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> (base == $past(base)));

    // R6: phase moves by exactly LANES mod 4 per accepted beat
    p_phase_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (2'(int'(base) - int'($past(base))) == 2'(STEP)));

    generate
        if (STEP == 0) begin : g_fixed_map
            // R5: with a lane count that is a multiple of 4 the base never moves
            p_base_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
                advance |=> (base == PH_ZERO));
        end
    endgenerate

endmodule

// File: rtl/qmix_lane.sv
module qmix_lane
    import qmix_pkg::*;
#(
    parameter int DW = 16
) (
    input  rot_phase_e            ph,
    input  logic signed [DW-1:0]  x,
    output logic signed [DW-1:0]  y_i,
    output logic signed [DW-1:0]  y_q
);

    localparam logic signed [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};
    localparam logic signed [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};

    logic signed [DW-1:0] neg_x;

    // Saturating negation: the most negative code maps to the most positive
    always_comb begin
        neg_x = (x == SMIN) ? SMAX : -x;
    end

    // Commutator: route x, -x or zero to I and Q by rotation phase
    always_comb begin
        y_i = '0;
        y_q = '0;
        unique case (ph)
            PH_ZERO:    y_i = x;
            PH_QUARTER: y_q = x;
            PH_HALF:    y_i = neg_x;
            PH_THREE_Q: y_q = neg_x;
        endcase
    end

endmodule

// File: rtl/qmix_quarter_rate.sv
module qmix_quarter_rate
    import qmix_pkg::*;
#(
    parameter int LANES = 8,
    parameter int DW    = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [LANES*DW-1:0]   in_samples,
    output logic                  out_valid,
    output logic [LANES*DW-1:0]   out_i,
    output logic [LANES*DW-1:0]   out_q
);

    localparam int VW = LANES * DW;
    localparam logic signed [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};
    localparam logic signed [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};

    rot_phase_e       base;
    rot_phase_e       lane_ph [LANES];
    logic [VW-1:0]    mix_i;
    logic [VW-1:0]    mix_q;

    qmix_phase_fsm #(
        .LANES (LANES)
    ) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (in_valid),
        .base    (base)
    );

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            assign lane_ph[k] = lane_phase(base, k);

            qmix_lane #(
                .DW (DW)
            ) u_lane (
                .ph  (lane_ph[k]),
                .x   (in_samples[k*DW +: DW]),
                .y_i (mix_i[k*DW +: DW]),
                .y_q (mix_q[k*DW +: DW])
            );

            // R11: I and Q of one lane are never both nonzero
            p_sparse_r11: assert property (@(posedge clk) disable iff (!rst_n)
                (out_i[k*DW +: DW] != '0) |-> (out_q[k*DW +: DW] == '0));

            // R7: minimum input on a negating I phase saturates
            p_sat_i_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && (in_samples[k*DW +: DW] == SMIN) && (lane_ph[k] == PH_HALF))
                |=> (out_i[k*DW +: DW] == SMAX));

            // R7: minimum input on a negating Q phase saturates
            p_sat_q_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && (in_samples[k*DW +: DW] == SMIN) && (lane_ph[k] == PH_THREE_Q))
                |=> (out_q[k*DW +: DW] == SMAX));
        end
    endgenerate

    // Output register: one cycle of latency, hold on idle beats
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_i <= mix_i;
                out_q <= mix_q;
            end
        end
    end

    // R8: valid follows the input strobe one cycle later
    p_valid_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9: data hold while no beat is accepted
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_i) && $stable(out_q)));

    // R10: reset clears the outputs
    p_reset_r10: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && (out_i == '0) && (out_q == '0)));

endmodule

// File: tb/test_qmix_quarter_rate.sv
module test_qmix_quarter_rate;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 16;
    localparam int L8         = 8;
    localparam int L6         = 6;
    localparam int SMIN       = -32768;
    localparam int SMAX       = 32767;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [L8*DW-1:0]  in_samples = '0;
    logic              o8_valid, o6_valid;
    logic [L8*DW-1:0]  o8_i, o8_q;
    logic [L6*DW-1:0]  o6_i, o6_q;

    int checks = 0;
    int fails  = 0;

    // Behavioural reference state
    int    x_now  [L8];
    int    e8_i   [L8];
    int    e8_q   [L8];
    string e8_tag [L8];
    int    e6_i   [L6];
    int    e6_q   [L6];
    string e6_tag [L6];
    bit    e_valid;
    int    base8, base6;

    always #(CLK_PERIOD/2) clk = ~clk;

    qmix_quarter_rate #(.LANES(L8), .DW(DW)) i_qmix_quarter_rate (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_samples (in_samples),
        .out_valid  (o8_valid),
        .out_i      (o8_i),
        .out_q      (o8_q)
    );

    qmix_quarter_rate #(.LANES(L6), .DW(DW)) i_qmix_quarter_rate_six (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_samples (in_samples[L6*DW-1:0]),
        .out_valid  (o6_valid),
        .out_i      (o6_i),
        .out_q      (o6_q)
    );

    function automatic int neg_sat(int x);
        return (x == SMIN) ? SMAX : -x;
    endfunction

    function automatic int mix(int x, int ph, bit want_q);
        case (ph)
            0: return want_q ? 0 : x;
            1: return want_q ? x : 0;
            2: return want_q ? 0 : neg_sat(x);
            default: return want_q ? neg_sat(x) : 0;
        endcase
    endfunction

    function automatic string phase_tag(int x, int ph);
        if (x == SMIN && (ph == 2 || ph == 3)) return "R7";
        case (ph)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check("R8", "out_valid (8 lanes)", int'(o8_valid), int'(e_valid));
        check("R8", "out_valid (6 lanes)", int'(o6_valid), int'(e_valid));
        for (int k = 0; k < L8; k++) begin
            int ai, aq;
            ai = int'($signed(o8_i[k*DW +: DW]));
            aq = int'($signed(o8_q[k*DW +: DW]));
            check({e8_tag[k], "/R5"}, $sformatf("lane %0d I (8 lanes)", k), ai, e8_i[k]);
            check({e8_tag[k], "/R5"}, $sformatf("lane %0d Q (8 lanes)", k), aq, e8_q[k]);
            check("R11", $sformatf("lane %0d sparsity (8 lanes)", k),
                  int'(ai != 0 && aq != 0), 0);
        end
        for (int k = 0; k < L6; k++) begin
            int ai, aq;
            ai = int'($signed(o6_i[k*DW +: DW]));
            aq = int'($signed(o6_q[k*DW +: DW]));
            check({e6_tag[k], "/R6"}, $sformatf("lane %0d I (6 lanes)", k), ai, e6_i[k]);
            check({e6_tag[k], "/R6"}, $sformatf("lane %0d Q (6 lanes)", k), aq, e6_q[k]);
        end
    endtask

    // Advance the model by the posedge that follows the current drive
    task automatic model_step(bit rst_val, bit v);
        if (!rst_val) begin
            for (int k = 0; k < L8; k++) begin
                e8_i[k] = 0; e8_q[k] = 0; e8_tag[k] = "R10";
            end
            for (int k = 0; k < L6; k++) begin
                e6_i[k] = 0; e6_q[k] = 0; e6_tag[k] = "R10";
            end
            base8 = 0; base6 = 0; e_valid = 1'b0;
        end else if (v) begin
            for (int k = 0; k < L8; k++) begin
                int ph;
                ph = (base8 + k) % 4;
                e8_i[k] = mix(x_now[k], ph, 1'b0);
                e8_q[k] = mix(x_now[k], ph, 1'b1);
                e8_tag[k] = phase_tag(x_now[k], ph);
            end
            for (int k = 0; k < L6; k++) begin
                int ph;
                ph = (base6 + k) % 4;
                e6_i[k] = mix(x_now[k], ph, 1'b0);
                e6_q[k] = mix(x_now[k], ph, 1'b1);
                e6_tag[k] = phase_tag(x_now[k], ph);
            end
            base8 = (base8 + L8) % 4;
            base6 = (base6 + L6) % 4;
            e_valid = 1'b1;
        end else begin
            for (int k = 0; k < L8; k++) e8_tag[k] = "R9";
            for (int k = 0; k < L6; k++) e6_tag[k] = "R9";
            e_valid = 1'b0;
        end
    endtask

    function automatic int pick_value(int c, int k);
        if (c < 40)  return c * 97 + k * 13 - 1500;
        if (c < 80)  return SMIN;
        if (c < 100) return SMAX;
        if (c < 130) return ((c + k) % 2 == 0) ? SMIN : SMAX;
        return int'($signed(16'($urandom())));
    endfunction

    function automatic bit pick_valid(int c);
        if (c < 50)  return 1'b1;
        if (c < 180) return ($urandom() % 3) != 0;
        if (c < 260) return (c % 2) == 0;
        return ($urandom() % 4) != 0;
    endfunction

    initial begin
        model_step(1'b0, 1'b0);
        for (int c = 0; c < 400; c++) begin
            bit r, v;
            @(negedge clk);
            compare_all();
            r = !(c < 3 || c == 210 || c == 211);
            v = pick_valid(c);
            for (int k = 0; k < L8; k++) begin
                x_now[k] = pick_value(c, k);
                in_samples[k*DW +: DW] = DW'(x_now[k]);
            end
            rst_n    = r;
            in_valid = v;
            model_step(r, v);
        end
        @(negedge clk);
        compare_all();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule